// File: doc/BRIEF.md
# DDR Command Bus Legality Monitor

This block sits beside the command bus of a four-bank DDR SDRAM and watches it on every rising clock edge. It turns the clock enable, chip select, row strobe, column strobe, write enable and A10 levels into a command code. It tracks which banks hold an open row, and it counts down the minimum cycle spacings that each bank and the whole device must respect. Any command that breaks a bank-state rule or comes too early raises a sticky violation flag. The first offending reason is kept as a code.

All spacings come in as whole clock counts on configuration inputs. Auto-precharge windows are formed from these counts. For a write with auto-precharge, the write-recovery and precharge terms are each rounded up to whole clocks before they are added, and that sum is the tDAL figure. Every output is registered. The edge that samples a command also updates the command code, the bank vector and the flags for that command.

Top module: `ddr_cmd_guard`

## Requirements
- R1: With clock enable high and chip select low, {ras,cas,we} decode to cmd_o as follows: 000 mode-set (2), 001 refresh (3), 010 precharge (4, or 5 for all-banks when A10 is high), 011 activate (6), 100 write (7, or 8 with auto-precharge when A10 is high), 101 read (9, or 10 with auto-precharge), 110 burst stop (11), 111 no-op (1). Chip select high gives 0. Clock enable low gives 12.
- R2: A deselect (chip select high) or a cycle with clock enable low changes neither bank_active_o nor the violation flags.
- R3: Bit b of bank_active_o is bank b. An activate sets the bit of the addressed bank. A precharge, a read with auto-precharge or a write with auto-precharge clears it. A precharge with A10 high clears all four bits and ignores the bank address.
- R4: A read or write to an idle bank sets reason 1. An activate to an open bank sets reason 2.
- R5: A read or write issued fewer than tRCD cycles after that bank's activate sets reason 3.
- R6: An activate issued fewer than tRRD cycles after the previous activate to any bank sets reason 4.
- R7: A read or write issued fewer than tCCD cycles after the previous read or write sets reason 5.
- R8: After a precharge closes an open bank at cycle n, an activate, read, write or single-bank precharge to that bank before cycle n+tRP sets reason 6.
- R9: After a read with auto-precharge at cycle n, any such command to that bank before cycle n+BL/2+tRP sets reason 6.
- R10: After a write with auto-precharge at cycle n, any such command to that bank before cycle n+BL/2+1+tWR+tRP sets reason 6. tWR and tRP are separately rounded whole clocks, so tWR=2 and tRP=3 give tDAL=5.
- R11: A mode-set while any bank is open sets reason 7. A mode-set fewer than tRP cycles after the last precharge command, or while any bank's precharge window is still running, sets reason 8.
- R12: Reason r sets viol_flags_o bit r-1, and the bit stays set until clear_i is sampled high. viol_reason_o keeps the first reason recorded since the last clear; when one command breaks several rules, the lowest code wins. A clear and a violation in the same cycle leave only the new violation.
- R13: After reset, cmd_o, bank_active_o, viol_flags_o and viol_reason_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of flags and reason |
| cke_i | input | 1 | Clock enable level |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| a10_i | input | 1 | Auto-precharge / all-banks select |
| ba_i | input | BAW | Bank address |
| bl_half_i | input | TW | Burst length divided by two, in clocks |
| t_rcd_i | input | TW | Activate to column command, clocks |
| t_rp_i | input | TW | Precharge period, clocks |
| t_rrd_i | input | TW | Activate to activate, clocks |
| t_ccd_i | input | TW | Column to column, clocks |
| t_wr_i | input | TW | Write recovery, clocks |
| cmd_o | output | 4 | Decoded command code |
| bank_active_o | output | 2**BAW | Open-row state per bank |
| viol_flags_o | output | 8 | Sticky flags, bit r-1 for reason r |
| viol_reason_o | output | 4 | First recorded reason code |

## Verification
On every cycle, assertions check four things. An activate or precharge moves the addressed bank bit. A deselected or clock-disabled cycle leaves the bank vector and flags untouched. An activate to an open bank always flags. Flags and the stored reason never drop without a clear. The exact cycle at which each spacing window opens can only be shown by the bench's sweeps. These sweeps cover tRCD, tRRD, tRP, tCCD, both auto-precharge windows (including the tDAL sum) and the mode-set gap over small parameter ranges, with each gap swept across the legal boundary. Priority between simultaneous reasons and a clear that lands with a new violation are also covered by scenarios only.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0, CMD_NOP = 4'd1, CMD_MRS = 4'd2, CMD_REF = 4'd3,
    CMD_PRE = 4'd4, CMD_PREA = 4'd5, CMD_ACT = 4'd6, CMD_WR = 4'd7,
    CMD_WRA = 4'd8, CMD_RD = 4'd9, CMD_RDA = 4'd10, CMD_BST = 4'd11,
    CMD_NOCLK = 4'd12
  } cmd_e;

  localparam int unsigned NUM_RSN = 8;
  localparam int unsigned RSN_W   = 4;
  localparam int unsigned RSN_IDLE   = 1;
  localparam int unsigned RSN_DACT   = 2;
  localparam int unsigned RSN_RCD    = 3;
  localparam int unsigned RSN_RRD    = 4;
  localparam int unsigned RSN_CCD    = 5;
  localparam int unsigned RSN_BUSY   = 6;
  localparam int unsigned RSN_MOPEN  = 7;
  localparam int unsigned RSN_MEARLY = 8;

  function automatic logic is_col(cmd_e c);
    return (c == CMD_RD) || (c == CMD_RDA) || (c == CMD_WR) || (c == CMD_WRA);
  endfunction
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_guard_pkg::*;
(
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic a10_i,
  output cmd_e cmd_o
);
  always_comb begin
    if (!cke_i)     cmd_o = CMD_NOCLK;
    else if (cs_ni) cmd_o = CMD_DESEL;
    else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b000:  cmd_o = CMD_MRS;
        3'b001:  cmd_o = CMD_REF;
        3'b010:  cmd_o = a10_i ? CMD_PREA : CMD_PRE;
        3'b011:  cmd_o = CMD_ACT;
        3'b100:  cmd_o = a10_i ? CMD_WRA : CMD_WR;
        3'b101:  cmd_o = a10_i ? CMD_RDA : CMD_RD;
        3'b110:  cmd_o = CMD_BST;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/ddr_gap_timer.sv
// Countdown of remaining blocked cycles; a load of N blocks the next N-1 edges.
module ddr_gap_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         pend_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= (len_i == '0) ? '0 : len_i - W'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign pend_o = (cnt_q != '0);

  assert_load_arms_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && len_i > W'(1)) |=> pend_o);

  assert_no_count_up_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
  import ddr_guard_pkg::*;
#(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cmd_e          cmd_i,
  input  logic          hit_i,
  input  logic [TW-1:0] bl_half_i,
  input  logic [TW-1:0] t_rcd_i,
  input  logic [TW-1:0] t_rp_i,
  input  logic [TW-1:0] t_wr_i,
  output logic          active_o,
  output logic          rcd_pend_o,
  output logic          busy_pend_o
);
  localparam int unsigned CW = TW + 2;

  logic          active_q;
  logic          act_hit, close_hit, busy_load;
  logic [CW-1:0] busy_len;

  assign act_hit   = hit_i && (cmd_i == CMD_ACT);
  assign close_hit = hit_i && ((cmd_i == CMD_PRE) || (cmd_i == CMD_PREA) ||
                               (cmd_i == CMD_RDA) || (cmd_i == CMD_WRA));

  always_comb begin
    busy_load = 1'b0;
    busy_len  = {2'b00, t_rp_i};
    if (hit_i) begin
      case (cmd_i)
        CMD_PRE, CMD_PREA: busy_load = active_q;
        CMD_RDA: begin
          busy_load = 1'b1;
          busy_len  = {2'b00, bl_half_i} + {2'b00, t_rp_i};
        end
        CMD_WRA: begin
          // recovery and precharge are separate whole-clock terms
          busy_load = 1'b1;
          busy_len  = {2'b00, bl_half_i} + CW'(1) + {2'b00, t_wr_i} + {2'b00, t_rp_i};
        end
        default: busy_load = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        active_q <= 1'b0;
    else if (act_hit)   active_q <= 1'b1;
    else if (close_hit) active_q <= 1'b0;
  end

  ddr_gap_timer #(.W(TW)) u_rcd (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(act_hit), .len_i(t_rcd_i), .pend_o(rcd_pend_o)
  );

  ddr_gap_timer #(.W(CW)) u_busy (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(busy_load), .len_i(busy_len), .pend_o(busy_pend_o)
  );

  assign active_o = active_q;

  assert_act_opens_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_hit |=> active_o);

  assert_pre_closes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && (cmd_i == CMD_PRE || cmd_i == CMD_PREA)) |=> !active_o);
endmodule

// File: rtl/ddr_viol_log.sv
module ddr_viol_log
  import ddr_guard_pkg::*;
#(
  parameter int unsigned NR = NUM_RSN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [NR-1:0]    hit_i,
  output logic [NR-1:0]    flags_o,
  output logic [RSN_W-1:0] reason_o
);
  logic [NR-1:0]    flags_q;
  logic [RSN_W-1:0] reason_q, first;

  always_comb begin
    first = '0;
    for (int i = NR - 1; i >= 0; i--) begin
      if (hit_i[i]) first = RSN_W'(i + 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q  <= '0;
      reason_q <= '0;
    end else begin
      flags_q <= (clear_i ? '0 : flags_q) | hit_i;
      if (clear_i || reason_q == '0) reason_q <= first;
    end
  end

  assign flags_o  = flags_q;
  assign reason_o = reason_q;

  assert_flags_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

  assert_reason_held_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && reason_o != '0) |=> reason_o == $past(reason_o));
endmodule

// File: rtl/ddr_cmd_guard.sv
module ddr_cmd_guard
  import ddr_guard_pkg::*;
#(
  parameter int unsigned TW  = 8,
  parameter int unsigned BAW = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    cke_i,
  input  logic                    cs_ni,
  input  logic                    ras_ni,
  input  logic                    cas_ni,
  input  logic                    we_ni,
  input  logic                    a10_i,
  input  logic [BAW-1:0]          ba_i,
  input  logic [TW-1:0]           bl_half_i,
  input  logic [TW-1:0]           t_rcd_i,
  input  logic [TW-1:0]           t_rp_i,
  input  logic [TW-1:0]           t_rrd_i,
  input  logic [TW-1:0]           t_ccd_i,
  input  logic [TW-1:0]           t_wr_i,
  output logic [3:0]              cmd_o,
  output logic [(1<<BAW)-1:0]     bank_active_o,
  output logic [NUM_RSN-1:0]      viol_flags_o,
  output logic [RSN_W-1:0]        viol_reason_o
);
  localparam int unsigned NB = 1 << BAW;

  cmd_e             cmd, cmd_q;
  logic [NB-1:0]    hit, active, rcd_pend, busy_pend;
  logic             rrd_pend, ccd_pend, mrs_pend;
  logic             col, sel_active, sel_rcd, sel_busy;
  logic [NUM_RSN-1:0] viol;

  ddr_cmd_decode u_dec (
    .cke_i(cke_i), .cs_ni(cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni),
    .we_ni(we_ni), .a10_i(a10_i), .cmd_o(cmd)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign hit[b] = (cmd == CMD_PREA) || (ba_i == BAW'(b));
    ddr_bank_track #(.TW(TW)) u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd), .hit_i(hit[b]),
      .bl_half_i(bl_half_i), .t_rcd_i(t_rcd_i), .t_rp_i(t_rp_i), .t_wr_i(t_wr_i),
      .active_o(active[b]), .rcd_pend_o(rcd_pend[b]), .busy_pend_o(busy_pend[b])
    );
  end

  ddr_gap_timer #(.W(TW)) u_rrd (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cmd == CMD_ACT), .len_i(t_rrd_i), .pend_o(rrd_pend)
  );
  ddr_gap_timer #(.W(TW)) u_ccd (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(is_col(cmd)), .len_i(t_ccd_i), .pend_o(ccd_pend)
  );
  ddr_gap_timer #(.W(TW)) u_mrs (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cmd == CMD_PRE || cmd == CMD_PREA),
    .len_i(t_rp_i), .pend_o(mrs_pend)
  );

  assign col        = is_col(cmd);
  assign sel_active = active[ba_i];
  assign sel_rcd    = rcd_pend[ba_i];
  assign sel_busy   = busy_pend[ba_i];

  always_comb begin
    viol = '0;
    viol[RSN_IDLE-1]   = col && !sel_active;
    viol[RSN_DACT-1]   = (cmd == CMD_ACT) && sel_active;
    viol[RSN_RCD-1]    = col && sel_active && sel_rcd;
    viol[RSN_RRD-1]    = (cmd == CMD_ACT) && rrd_pend;
    viol[RSN_CCD-1]    = col && ccd_pend;
    viol[RSN_BUSY-1]   = (col || cmd == CMD_ACT || cmd == CMD_PRE) && sel_busy;
    viol[RSN_MOPEN-1]  = (cmd == CMD_MRS) && (|active);
    viol[RSN_MEARLY-1] = (cmd == CMD_MRS) && (mrs_pend || (|busy_pend));
  end

  ddr_viol_log #(.NR(NUM_RSN)) u_log (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .hit_i(viol),
    .flags_o(viol_flags_o), .reason_o(viol_reason_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= CMD_DESEL;
    else         cmd_q <= cmd;
  end

  assign cmd_o         = cmd_q;
  assign bank_active_o = active;

  assert_quiet_banks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || !cke_i) |=> bank_active_o == $past(bank_active_o));

  assert_quiet_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && (cs_ni || !cke_i)) |=> viol_flags_o == $past(viol_flags_o));

  assert_double_act_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_i && !cs_ni && !ras_ni && cas_ni && we_ni && bank_active_o[ba_i])
      |=> viol_flags_o[RSN_DACT-1]);
endmodule

// File: tb/ddr_cmd_guard_tb_top.sv
module ddr_cmd_guard_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = '0;
  logic [7:0] bl_half = 8'd2, t_rcd = 8'd2, t_rp = 8'd2, t_rrd = 8'd1, t_ccd = 8'd1, t_wr = 8'd2;
  logic [3:0] cmd;
  logic [3:0] bank_act;
  logic [7:0] flags;
  logic [3:0] reason;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  ddr_cmd_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .cke_i(cke), .cs_ni(cs_n),
    .ras_ni(ras_n), .cas_ni(cas_n), .we_ni(we_n), .a10_i(a10), .ba_i(ba),
    .bl_half_i(bl_half), .t_rcd_i(t_rcd), .t_rp_i(t_rp), .t_rrd_i(t_rrd),
    .t_ccd_i(t_ccd), .t_wr_i(t_wr), .cmd_o(cmd), .bank_active_o(bank_act),
    .viol_flags_o(flags), .viol_reason_o(reason)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic c, input logic w, input logic a, input logic [1:0] b);
    cs_n = 1'b0; ras_n = r; cas_n = c; we_n = w; a10 = a; ba = b;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic act(input logic [1:0] b);                 drive(1'b0, 1'b1, 1'b1, 1'b0, b); endtask
  task automatic rd(input logic [1:0] b, input logic ap);  drive(1'b1, 1'b0, 1'b1, ap, b);   endtask
  task automatic wr(input logic [1:0] b, input logic ap);  drive(1'b1, 1'b0, 1'b0, ap, b);   endtask
  task automatic pre(input logic [1:0] b, input logic al); drive(1'b0, 1'b1, 1'b0, al, b);   endtask
  task automatic mrs();                                    drive(1'b0, 1'b0, 1'b0, 1'b0, 2'd0); endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) begin
      cs_n = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic do_clear();
    cs_n = 1'b1; clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic settle();
    pre(2'd0, 1'b1);
    nop(20);
    do_clear();
  endtask

  function automatic int exp_code(input int v, input int a);
    case (v)
      0: return 2;
      1: return 3;
      2: return a ? 5 : 4;
      3: return 6;
      4: return a ? 8 : 7;
      5: return a ? 10 : 9;
      6: return 11;
      default: return 1;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 cmd after reset", cmd, 0);
    chk("R13 banks after reset", bank_act, 0);
    chk("R13 flags after reset", flags, 0);
    chk("R13 reason after reset", reason, 0);

    // R1 decode sweep
    for (int v = 0; v < 8; v++) begin
      for (int a = 0; a < 2; a++) begin
        drive(v[2], v[1], v[0], a[0], 2'd1);
        chk($sformatf("R1 decode ras/cas/we=%0d a10=%0d", v, a), cmd, exp_code(v, a));
      end
    end
    nop(1);
    chk("R1 deselect code", cmd, 0);
    cke = 1'b0; drive(1'b1, 1'b0, 1'b1, 1'b0, 2'd1); cke = 1'b1;
    chk("R1 clock-enable low code", cmd, 12);
    settle();

    // R2 ignored cycles
    cs_n = 1'b1; ras_n = 1'b0; cas_n = 1'b1; we_n = 1'b1; ba = 2'd2;
    @(negedge clk);
    chk("R2 deselected activate banks", bank_act, 0);
    cke = 1'b0; cs_n = 1'b0; @(negedge clk); cke = 1'b1; cs_n = 1'b1;
    chk("R2 cke low activate banks", bank_act, 0);
    chk("R2 cke low activate code", cmd, 12);
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b1; @(negedge clk);
    chk("R2 deselected read flags", flags, 0);

    // R3 bank state
    settle();
    act(2'd0); act(2'd1);
    chk("R3 two open", bank_act, 3);
    pre(2'd1, 1'b0);
    chk("R3 single precharge", bank_act, 1);
    act(2'd3);
    chk("R3 open bank3", bank_act, 9);
    pre(2'd2, 1'b1);
    chk("R3 all-bank precharge ignores ba", bank_act, 0);

    // R4 state rules
    settle(); rd(2'd1, 1'b0);
    chk("R4 read idle bank", flags[0], 1);
    settle(); wr(2'd2, 1'b0);
    chk("R4 write idle bank", flags[0], 1);
    settle(); act(2'd0); nop(2); act(2'd0);
    chk("R4 double activate", flags[1], 1);
    settle(); t_rcd = 8'd1; act(2'd0); nop(3); rd(2'd0, 1'b0);
    chk("R4 legal read no flags", flags, 0);

    // R5 tRCD sweep
    for (int tr = 1; tr <= 4; tr++) begin
      for (int g = 1; g <= 5; g++) begin
        t_rcd = 8'(tr); settle();
        act(2'd1); nop(g - 1); rd(2'd1, 1'b0);
        chk($sformatf("R5 trcd=%0d gap=%0d", tr, g), flags[2], (g < tr) ? 1 : 0);
      end
    end
    t_rcd = 8'd1;

    // R6 tRRD sweep
    for (int tr = 1; tr <= 3; tr++) begin
      for (int g = 1; g <= 4; g++) begin
        t_rrd = 8'(tr); settle();
        act(2'd0); nop(g - 1); act(2'd2);
        chk($sformatf("R6 trrd=%0d gap=%0d", tr, g), flags[3], (g < tr) ? 1 : 0);
        chk("R3 banks 0 and 2 open", bank_act, 5);
      end
    end
    t_rrd = 8'd1;

    // R7 tCCD sweep
    for (int tc = 1; tc <= 3; tc++) begin
      for (int g = 1; g <= 4; g++) begin
        t_ccd = 8'(tc); settle();
        act(2'd0); rd(2'd0, 1'b0); nop(g - 1); wr(2'd0, 1'b0);
        chk($sformatf("R7 tccd=%0d gap=%0d", tc, g), flags[4], (g < tc) ? 1 : 0);
      end
    end
    t_ccd = 8'd1;

    // R8 precharge window
    for (int tp = 1; tp <= 4; tp++) begin
      for (int g = 1; g <= 5; g++) begin
        t_rp = 8'(tp); settle();
        act(2'd3); nop(1); pre(2'd3, 1'b0);
        nop(g - 1); act(2'd3);
        chk($sformatf("R8 trp=%0d gap=%0d", tp, g), flags[5], (g < tp) ? 1 : 0);
      end
    end

    // R9 read auto-precharge window
    for (int k = 0; k < 3; k++) begin
      for (int tp = 2; tp <= 3; tp++) begin
        int x;
        x = (1 << k) + tp;
        for (int g = 1; g <= x + 1; g++) begin
          bl_half = 8'(1 << k); t_rp = 8'(tp); settle();
          act(2'd2); rd(2'd2, 1'b1);
          if (g == 1) chk("R3 read-ap closes bank", bank_act[2], 0);
          nop(g - 1); act(2'd2);
          chk($sformatf("R9 bl2=%0d trp=%0d gap=%0d", 1 << k, tp, g), flags[5], (g < x) ? 1 : 0);
        end
      end
    end

    // R10 write auto-precharge window; twr=2,trp=3 is the tDAL=5 case
    for (int k = 0; k < 3; k++) begin
      for (int tw = 1; tw <= 2; tw++) begin
        for (int tp = 2; tp <= 3; tp++) begin
          int x;
          x = (1 << k) + 1 + tw + tp;
          for (int g = 1; g <= x + 1; g++) begin
            bl_half = 8'(1 << k); t_wr = 8'(tw); t_rp = 8'(tp); settle();
            act(2'd1); wr(2'd1, 1'b1);
            nop(g - 1); act(2'd1);
            chk($sformatf("R10 bl2=%0d twr=%0d trp=%0d gap=%0d", 1 << k, tw, tp, g),
                flags[5], (g < x) ? 1 : 0);
          end
        end
      end
    end
    bl_half = 8'd2; t_wr = 8'd2;

    // R11 mode-set rules
    t_rp = 8'd3; settle();
    act(2'd0); nop(1); mrs();
    chk("R11 mode-set with open bank", flags[6], 1);
    for (int g = 1; g <= 4; g++) begin
      settle();
      act(2'd0); nop(1); pre(2'd0, 1'b1); nop(g - 1); mrs();
      chk($sformatf("R11 mode-set gap=%0d", g), flags[7], (g < 3) ? 1 : 0);
      chk("R11 no open-bank flag", flags[6], 0);
    end
    t_rp = 8'd2;

    // R12 sticky flags, first reason, priority, clear
    t_rcd = 8'd3; settle();
    act(2'd1); rd(2'd1, 1'b0);
    chk("R12 reason rcd", reason, 3);
    nop(3);
    chk("R12 flag held", flags[2], 1);
    rd(2'd2, 1'b0);
    chk("R12 flags accumulate", flags, 8'h05);
    chk("R12 first reason kept", reason, 3);
    do_clear();
    chk("R12 clear flags", flags, 0);
    chk("R12 clear reason", reason, 0);
    settle();
    act(2'd2); nop(2); rd(2'd2, 1'b1); rd(2'd2, 1'b0);
    chk("R12 idle+busy flags", flags, 8'h21);
    chk("R12 lowest reason wins", reason, 1);
    clear = 1'b1; rd(2'd3, 1'b0); clear = 1'b0;
    chk("R12 clear with new violation flags", flags, 8'h01);
    chk("R12 clear with new violation reason", reason, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule